// File: doc/BRIEF.md
# Subfarm Event Dispatcher with Timeouts

This block hands first-level trigger events to a small pool of worker nodes. Each worker owns a single token: while the token sits in the free pool the worker may receive an event, and it leaves the pool until the worker answers. Each accepted event waits in a timestamped FIFO. The oldest entry goes to a free worker picked by round-robin. The dispatch carries the number of cycles the event waited, as its age penalty.

Dispatch arms a per-worker timer. If the worker reports its decision while the timer is below the programmed limit, the decision goes out on the decision port with the event number. If the limit is reached first, the block sends a programmable default decision and marks it as a timeout. The worker's token stays out of the pool until the worker finally answers, and that late answer is thrown away. When every worker is occupied, queued events age. The oldest one is dropped once its age reaches a programmed limit.

Top module: `subfarm_dispatch`

## Requirements
- R1: After reset, evt_ready is 1, disp_valid, dec_valid and drop_valid are 0, and all workers hold their tokens in the free pool.
- R2: An event offered with evt_valid while evt_ready is 1 is accepted at that clock edge. A free worker is granted at the next edge, and disp_valid is seen one cycle after that. Grants are round-robin: the search starts at worker 0 after reset, then at the index after the last grant.
- R3: disp_penalty equals the number of cycles from the acceptance cycle to the dispatch cycle. Its minimum is 1.
- R4: Cycle 0 is the first cycle after the dispatch edge. A decision (done_valid, done_idx) from a busy worker presented in cycle k with k < proc_limit is sent in the next cycle with the worker's done_dec, its event number and dec_timeout = 0. The worker's token then returns to the pool.
- R5: A worker receives an event only while its token is free, so it never holds more than one event.
- R6: If a busy worker has not answered by cycle proc_limit, default_dec is sent with dec_timeout = 1 and that worker's event number.
- R7: After a timeout, the worker is not offered events until it answers. That late answer produces no decision output and returns its token.
- R8: While no worker is free, accepted events are held and later dispatched in arrival order.
- R9: When no worker is free and the oldest queued event has an age of at least age_limit, that event is removed. drop_valid and drop_evt report it in the following cycle.
- R10: evt_ready is 0 while the FIFO is full. An event offered then is ignored and is never dispatched.
- R11: At most one decision leaves per cycle. A decision from a busy worker has priority over pending timeouts. Pending timeouts go out lowest index first in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | New event offered |
| evt_id | input | EVT_W | Event number |
| evt_ready | output | 1 | FIFO can take an event |
| proc_limit | input | TS_W | Maximum processing cycles per worker |
| age_limit | input | TS_W | Maximum queue age before discard |
| default_dec | input | DEC_W | Decision sent on timeout |
| done_valid | input | 1 | A worker reports a decision |
| done_idx | input | log2(N_WORKERS) | Reporting worker |
| done_dec | input | DEC_W | Reported decision |
| disp_valid | output | 1 | Event sent to a worker |
| disp_worker | output | log2(N_WORKERS) | Receiving worker |
| disp_evt | output | EVT_W | Event number sent |
| disp_penalty | output | TS_W | Cycles the event waited |
| dec_valid | output | 1 | Decision to the sorter |
| dec_evt | output | EVT_W | Event of the decision |
| dec_value | output | DEC_W | Decision value |
| dec_timeout | output | 1 | Decision is the default after timeout |
| drop_valid | output | 1 | Aged event discarded |
| drop_evt | output | EVT_W | Discarded event number |

## Verification
The hardest state to reach is a worker that has timed out but still withholds its token while the other workers are busy. Only then does the missing token decide whether a queued event is dispatched. The stimulus times out worker 0 first, then sends enough events to occupy the remaining workers and leave one queued. It then delivers worker 0's late answer and expects no decision output, followed one cycle later by the queued event going to worker 0 with a penalty of 3. A second hard case is a timeout that falls in the same cycle as another worker's answer. The stimulus offsets two dispatches by one cycle, which places them there.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic [1:0] {
    W_FREE    = 2'd0,
    W_BUSY    = 2'd1,
    W_EXPIRED = 2'd2
  } wstate_e;
endpackage

// File: rtl/sfd_evt_fifo.sv
module sfd_evt_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp_q, wp_d, rp_q, rp_d;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW-1:0] == rp_q[AW-1:0]) && (wp_q[AW] != rp_q[AW]);
  assign head  = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (push) wp_d = wp_q + 1'b1;
    if (pop)  rp_d = rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[AW-1:0]] <= push_data;
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sfd_rr_pick.sv
module sfd_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[(int'(ptr) + k) % N]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'((int'(ptr) + k) % N);
      end
    end
  end
endmodule

// File: rtl/sfd_worker_slot.sv
module sfd_worker_slot
  import sfd_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EVT_W-1:0] start_evt,
  input  logic             done,
  input  logic             tmo_ack,
  input  logic [TS_W-1:0]  limit,
  output logic             is_free,
  output logic             is_busy,
  output logic             overdue,
  output logic [EVT_W-1:0] evt
);
  wstate_e          st_q, st_d;
  logic [TS_W-1:0]  cnt_q, cnt_d;
  logic [EVT_W-1:0] evt_q, evt_d;

  assign is_free = (st_q == W_FREE);
  assign is_busy = (st_q == W_BUSY);
  assign overdue = is_busy && (cnt_q >= limit);
  assign evt     = evt_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    evt_d = evt_q;
    unique case (st_q)
      W_FREE: if (start) begin
        st_d  = W_BUSY;
        cnt_d = '0;
        evt_d = start_evt;
      end
      W_BUSY: begin
        if (done)         st_d = W_FREE;
        else if (tmo_ack) st_d = W_EXPIRED;
        else if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
      end
      W_EXPIRED: if (done) st_d = W_FREE;
      default: st_d = W_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_FREE;
      cnt_q <= '0;
      evt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      evt_q <= evt_d;
    end
  end

  assert_start_only_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == W_FREE));
  assert_ack_only_overdue_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ack |-> overdue);
endmodule

// File: rtl/subfarm_dispatch.sv
module subfarm_dispatch #(
  parameter int N_WORKERS = 4,
  parameter int Q_DEPTH   = 4,
  parameter int EVT_W     = 8,
  parameter int DEC_W     = 8,
  parameter int TS_W      = 16,
  localparam int WID_W    = (N_WORKERS > 1) ? $clog2(N_WORKERS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [EVT_W-1:0] evt_id,
  output logic             evt_ready,
  input  logic [TS_W-1:0]  proc_limit,
  input  logic [TS_W-1:0]  age_limit,
  input  logic [DEC_W-1:0] default_dec,
  input  logic             done_valid,
  input  logic [WID_W-1:0] done_idx,
  input  logic [DEC_W-1:0] done_dec,
  output logic             disp_valid,
  output logic [WID_W-1:0] disp_worker,
  output logic [EVT_W-1:0] disp_evt,
  output logic [TS_W-1:0]  disp_penalty,
  output logic             dec_valid,
  output logic [EVT_W-1:0] dec_evt,
  output logic [DEC_W-1:0] dec_value,
  output logic             dec_timeout,
  output logic             drop_valid,
  output logic [EVT_W-1:0] drop_evt
);
  localparam int QE_W = EVT_W + TS_W;

  // free-running timestamp
  logic [TS_W-1:0] now_q, now_d;

  // queue
  logic            q_push, q_pop, q_empty, q_full;
  logic [QE_W-1:0] q_head;
  logic [EVT_W-1:0] head_evt;
  logic [TS_W-1:0] head_ts, head_age;

  // worker pool
  logic [N_WORKERS-1:0] free_vec, busy_vec, overdue_vec, start_vec, done_vec, ack_vec;
  logic [EVT_W-1:0]     slot_evt [N_WORKERS];

  logic             gnt_valid;
  logic [WID_W-1:0] gnt_idx, rr_q, rr_d;
  logic             dispatch_go, drop_go, done_hit;
  logic             tmo_found;
  logic [WID_W-1:0] tmo_idx;

  // registered outputs, next values
  logic             disp_valid_d, dec_valid_d, dec_timeout_d, drop_valid_d;
  logic [WID_W-1:0] disp_worker_d;
  logic [EVT_W-1:0] disp_evt_d, dec_evt_d, drop_evt_d;
  logic [TS_W-1:0]  disp_penalty_d;
  logic [DEC_W-1:0] dec_value_d;

  assign evt_ready = !q_full;
  assign q_push    = evt_valid && !q_full;
  assign q_pop     = dispatch_go || drop_go;
  assign head_evt  = q_head[QE_W-1:TS_W];
  assign head_ts   = q_head[TS_W-1:0];
  assign head_age  = now_q - head_ts;

  sfd_evt_fifo #(.DEPTH(Q_DEPTH), .DW(QE_W)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data({evt_id, now_q}),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  sfd_rr_pick #(.N(N_WORKERS), .IW(WID_W)) i_pick (
    .req(free_vec), .ptr(rr_q), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  assign dispatch_go = !q_empty && gnt_valid;
  assign drop_go     = !q_empty && !gnt_valid && (head_age >= age_limit);
  assign done_hit    = done_valid && busy_vec[done_idx];

  // lowest-index pending timeout
  always_comb begin
    tmo_found = 1'b0;
    tmo_idx   = '0;
    for (int i = N_WORKERS - 1; i >= 0; i--) begin
      if (overdue_vec[i]) begin
        tmo_found = 1'b1;
        tmo_idx   = WID_W'(i);
      end
    end
  end

  for (genvar g = 0; g < N_WORKERS; g++) begin : g_slot
    assign start_vec[g] = dispatch_go && (gnt_idx == WID_W'(g));
    assign done_vec[g]  = done_valid && (done_idx == WID_W'(g));
    assign ack_vec[g]   = !done_hit && tmo_found && (tmo_idx == WID_W'(g));
    sfd_worker_slot #(.TS_W(TS_W), .EVT_W(EVT_W)) i_slot (
      .clk(clk), .rst_n(rst_n),
      .start(start_vec[g]), .start_evt(head_evt),
      .done(done_vec[g]), .tmo_ack(ack_vec[g]), .limit(proc_limit),
      .is_free(free_vec[g]), .is_busy(busy_vec[g]),
      .overdue(overdue_vec[g]), .evt(slot_evt[g])
    );
  end

  always_comb begin
    now_d          = now_q + 1'b1;
    rr_d           = rr_q;
    disp_valid_d   = dispatch_go;
    disp_worker_d  = gnt_idx;
    disp_evt_d     = head_evt;
    disp_penalty_d = head_age;
    drop_valid_d   = drop_go;
    drop_evt_d     = head_evt;
    dec_valid_d    = 1'b0;
    dec_evt_d      = '0;
    dec_value_d    = '0;
    dec_timeout_d  = 1'b0;
    if (dispatch_go)
      rr_d = (gnt_idx == WID_W'(N_WORKERS - 1)) ? '0 : gnt_idx + 1'b1;
    if (done_hit) begin
      dec_valid_d   = 1'b1;
      dec_evt_d     = slot_evt[done_idx];
      dec_timeout_d = overdue_vec[done_idx];
      dec_value_d   = overdue_vec[done_idx] ? default_dec : done_dec;
    end else if (tmo_found) begin
      dec_valid_d   = 1'b1;
      dec_evt_d     = slot_evt[tmo_idx];
      dec_timeout_d = 1'b1;
      dec_value_d   = default_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q        <= '0;
      rr_q         <= '0;
      disp_valid   <= 1'b0;
      disp_worker  <= '0;
      disp_evt     <= '0;
      disp_penalty <= '0;
      dec_valid    <= 1'b0;
      dec_evt      <= '0;
      dec_value    <= '0;
      dec_timeout  <= 1'b0;
      drop_valid   <= 1'b0;
      drop_evt     <= '0;
    end else begin
      now_q        <= now_d;
      rr_q         <= rr_d;
      disp_valid   <= disp_valid_d;
      disp_worker  <= disp_worker_d;
      disp_evt     <= disp_evt_d;
      disp_penalty <= disp_penalty_d;
      dec_valid    <= dec_valid_d;
      dec_evt      <= dec_evt_d;
      dec_value    <= dec_value_d;
      dec_timeout  <= dec_timeout_d;
      drop_valid   <= drop_valid_d;
      drop_evt     <= drop_evt_d;
    end
  end

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_vec));
  assert_penalty_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_penalty != '0));
  assert_disp_drop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_valid && drop_valid));
  assert_default_on_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_timeout) |-> (dec_value == $past(default_dec)));
endmodule

// File: tb/test_subfarm_dispatch.sv
module test_subfarm_dispatch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic [7:0] evt_id = '0;
  logic       evt_ready;
  logic [15:0] proc_limit = 16'd10;
  logic [15:0] age_limit = 16'd50;
  logic [7:0] default_dec = 8'hDD;
  logic       done_valid = 1'b0;
  logic [1:0] done_idx = '0;
  logic [7:0] done_dec = '0;
  logic       disp_valid;
  logic [1:0] disp_worker;
  logic [7:0] disp_evt;
  logic [15:0] disp_penalty;
  logic       dec_valid;
  logic [7:0] dec_evt;
  logic [7:0] dec_value;
  logic       dec_timeout;
  logic       drop_valid;
  logic [7:0] drop_evt;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  subfarm_dispatch i_subfarm_dispatch (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_id(evt_id),
    .evt_ready(evt_ready), .proc_limit(proc_limit), .age_limit(age_limit),
    .default_dec(default_dec), .done_valid(done_valid), .done_idx(done_idx),
    .done_dec(done_dec), .disp_valid(disp_valid), .disp_worker(disp_worker),
    .disp_evt(disp_evt), .disp_penalty(disp_penalty), .dec_valid(dec_valid),
    .dec_evt(dec_evt), .dec_value(dec_value), .dec_timeout(dec_timeout),
    .drop_valid(drop_valid), .drop_evt(drop_evt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    evt_valid = 1'b0; done_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_disp(input string req, input int w, input int e, input int pen);
    chk({req, " disp_valid"}, disp_valid, 1);
    chk({req, " disp_worker"}, disp_worker, w);
    chk({req, " disp_evt"}, disp_evt, e);
    if (pen >= 0) chk({req, " disp_penalty"}, disp_penalty, pen);
  endtask

  task automatic chk_dec(input string req, input int e, input int v, input int t);
    chk({req, " dec_valid"}, dec_valid, 1);
    chk({req, " dec_evt"}, dec_evt, e);
    chk({req, " dec_value"}, dec_value, v);
    chk({req, " dec_timeout"}, dec_timeout, t);
  endtask

  // offer n events on consecutive cycles; check early dispatches
  task automatic fill(input int base, input int n);
    for (int k = 0; k < n; k++) begin
      evt_valid = 1'b1; evt_id = 8'(base + k);
      if (k >= 2 && k - 2 < 4) chk_disp("R2 rr fill", k - 2, base + k - 2, 1);
      @(negedge clk);
    end
    evt_valid = 1'b0;
    if (n == 5) chk_disp("R2 rr fill", 3, base + 3, 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 evt_ready", evt_ready, 1);
    chk("R1 disp_valid", disp_valid, 0);
    chk("R1 dec_valid", dec_valid, 0);
    chk("R1 drop_valid", drop_valid, 0);
  endtask

  task automatic t_direct();
    do_reset(); proc_limit = 16'd10; age_limit = 16'd50;
    evt_valid = 1'b1; evt_id = 8'h11;
    @(negedge clk); evt_valid = 1'b0;
    @(negedge clk);
    chk_disp("R2 R3 first", 0, 8'h11, 1);
    done_valid = 1'b1; done_idx = 2'd0; done_dec = 8'h5A;
    @(negedge clk); done_valid = 1'b0;
    chk_dec("R4 in time", 8'h11, 8'h5A, 0);
    evt_valid = 1'b1; evt_id = 8'h12;
    @(negedge clk); evt_valid = 1'b0;
    @(negedge clk);
    chk_disp("R2 rr next", 1, 8'h12, 1);
  endtask

  task automatic t_queue();
    do_reset(); proc_limit = 16'd1000; age_limit = 16'd20;
    fill(8'hA0, 5);
    @(negedge clk);
    chk("R8 held no free", disp_valid, 0);
    done_valid = 1'b1; done_idx = 2'd2; done_dec = 8'h3C;
    @(negedge clk); done_valid = 1'b0;
    chk_dec("R4 worker2", 8'hA2, 8'h3C, 0);
    @(negedge clk);
    chk_disp("R8 R3 queued", 2, 8'hA4, 3);
  endtask

  task automatic t_timeout();
    do_reset(); proc_limit = 16'd3; age_limit = 16'd50; default_dec = 8'hDD;
    evt_valid = 1'b1; evt_id = 8'hB0;
    @(negedge clk); evt_valid = 1'b0;
    @(negedge clk);
    chk_disp("R6 setup", 0, 8'hB0, 1);
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      chk("R6 no early decision", dec_valid, 0);
    end
    @(negedge clk);
    chk_dec("R6 default", 8'hB0, 8'hDD, 1);
    proc_limit = 16'd1000;
    for (int k = 0; k < 4; k++) begin
      evt_valid = 1'b1; evt_id = 8'(8'hC1 + k);
      if (k >= 2) chk_disp("R7 others", k - 1, 8'hC1 + k - 2, 1);
      @(negedge clk);
    end
    evt_valid = 1'b0;
    chk_disp("R7 others", 3, 8'hC3, 1);
    @(negedge clk);
    chk("R7 token withheld", disp_valid, 0);
    chk("R7 no repeat timeout", dec_valid, 0);
    done_valid = 1'b1; done_idx = 2'd0; done_dec = 8'h77;
    @(negedge clk); done_valid = 1'b0;
    chk("R7 late ignored", dec_valid, 0);
    @(negedge clk);
    chk_disp("R7 token back", 0, 8'hC4, 3);
  endtask

  task automatic t_age();
    do_reset(); proc_limit = 16'd1000; age_limit = 16'd4;
    fill(8'hD0, 5);
    for (int j = 0; j < 3; j++) begin
      chk("R9 not yet dropped", drop_valid, 0);
      @(negedge clk);
    end
    chk("R9 not yet dropped", drop_valid, 0);
    @(negedge clk);
    chk("R9 drop_valid", drop_valid, 1);
    chk("R9 drop_evt", drop_evt, 8'hD4);
    done_valid = 1'b1; done_idx = 2'd0; done_dec = 8'h01;
    @(negedge clk); done_valid = 1'b0;
    @(negedge clk);
    chk("R9 queue emptied", disp_valid, 0);
  endtask

  task automatic t_full();
    do_reset(); proc_limit = 16'd1000; age_limit = 16'd100;
    fill(8'hE0, 8);
    chk("R10 evt_ready full", evt_ready, 0);
    evt_valid = 1'b1; evt_id = 8'hFF;
    done_valid = 1'b1; done_idx = 2'd0;
    @(negedge clk); evt_valid = 1'b0; done_idx = 2'd1;
    @(negedge clk); chk_disp("R10 R8 order", 0, 8'hE4, -1); done_idx = 2'd2;
    @(negedge clk); chk_disp("R10 R8 order", 1, 8'hE5, -1); done_idx = 2'd3;
    @(negedge clk); chk_disp("R10 R8 order", 2, 8'hE6, -1); done_idx = 2'd0;
    @(negedge clk); chk_disp("R10 R8 order", 3, 8'hE7, -1); done_valid = 1'b0;
    @(negedge clk);
    chk("R10 rejected event absent", disp_valid, 0);
    chk("R10 evt_ready back", evt_ready, 1);
  endtask

  task automatic t_collide();
    do_reset(); proc_limit = 16'd3; age_limit = 16'd50; default_dec = 8'hDD;
    evt_valid = 1'b1; evt_id = 8'hF0;
    @(negedge clk); evt_id = 8'hF1;
    @(negedge clk); evt_valid = 1'b0;
    chk_disp("R11 setup", 0, 8'hF0, 1);
    @(negedge clk); chk_disp("R11 setup", 1, 8'hF1, 1);
    @(negedge clk); chk("R11 idle", dec_valid, 0);
    @(negedge clk); chk("R11 idle", dec_valid, 0);
    done_valid = 1'b1; done_idx = 2'd1; done_dec = 8'h44;
    @(negedge clk); done_valid = 1'b0;
    chk_dec("R11 answer first", 8'hF1, 8'h44, 0);
    @(negedge clk);
    chk_dec("R11 timeout deferred", 8'hF0, 8'hDD, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_queue();
    t_timeout();
    t_age();
    t_full();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule